// File: doc/BRIEF.md
# Software Command Sequence Detector

This block sits on the control and address pins of an asynchronous SRAM-style memory and watches for a hidden command. The bus is modelled synchronously. Each bus cycle is marked by one access strobe, and chip enable, write enable, output enable and the address are sampled at that strobe. The block decodes every cycle into standby, read or write, and it drives the output enable for the shared data bus.

It also runs an unlock matcher over the sequence of read addresses. When five fixed key addresses arrive in order and are followed by a valid command address, the block raises one of four command pulses: autostore off, autostore on, nonvolatile store or nonvolatile recall. A status flag shows whether autostore is enabled. On the sixth cycle of a store or recall sequence, the data bus is left floating instead of returning read data.

The matcher is a six-state machine:
- `ST_IDLE` waits for the first key.
- `ST_K1` through `ST_K5` record that one to five keys have matched.

Its transitions are:
- **advance**: an expected key is read.
- **restart**: a mismatching read at 0x4E38 goes to `ST_K1`.
- **drop**: any other mismatching read goes to `ST_IDLE`.
- **abort**: a write goes to `ST_IDLE`.
- **fire**: a valid sixth address is read in `ST_K5`. A pulse is issued and the state returns to `ST_IDLE`.
- **reject**: an invalid sixth address is read in `ST_K5`. The state returns to `ST_IDLE` with no pulse.
- **hold**: the state does not change when the strobe is low or chip enable is high.

Top module: `nv_cmd_detect`

## Requirements
- R1: While ce_n is 1, mode is 0 (standby) and io_oe is 0. A strobe taken with ce_n at 1 leaves the matcher state unchanged.
- R2: While ce_n is 0 and we_n is 0, mode is 2 (write) and io_oe is 0, whatever the value of oe_n.
- R3: While ce_n is 0 and we_n is 1, mode is 1 (read). io_oe equals the inverse of oe_n, except in the case given in R8.
- R4: The unlock sequence is strobed reads at keys 0x4E38, 0xB1C7, 0x83E0, 0x7C1F and 0x703F, in that order. Cycles with the strobe low do not count. A command pulse is high during the clock that follows the edge where the sixth read is sampled.
- R5: The sixth read address selects the command. 0x8B45 raises cmd_as_off, 0x4B46 raises cmd_as_on, 0x8FC0 raises cmd_store and 0x4C63 raises cmd_recall. Any other sixth address returns the matcher to idle and raises no pulse.
- R6: Only addr[15:0] is compared against the keys, so addr[16] has no effect on matching.
- R7: A strobed write at any step returns the matcher to idle. A strobed read that is not the expected key also returns it to idle, except that a read at 0x4E38 restarts the sequence at step one.
- R8: On the sixth cycle, with five keys matched and addr[15:0] equal to 0x8FC0 or 0x4C63, io_oe is 0. On the sixth cycle at 0x8B45 or 0x4B46, io_oe follows oe_n as in R3.
- R9: At most one command pulse is high in any clock, and each pulse lasts exactly one clock.
- R10: autostore_on is 1 after reset. It becomes 0 in the clock after a cmd_as_off pulse and 1 in the clock after a cmd_as_on pulse. Store and recall pulses leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 17 | Bus address |
| strobe | input | 1 | One-clock marker of a bus access |
| cmd_as_off | output | 1 | Autostore-disable command pulse |
| cmd_as_on | output | 1 | Autostore-enable command pulse |
| cmd_store | output | 1 | Nonvolatile store command pulse |
| cmd_recall | output | 1 | Nonvolatile recall command pulse |
| autostore_on | output | 1 | Autostore enabled flag |
| mode | output | 2 | 0 standby, 1 read, 2 write |
| io_oe | output | 1 | Data bus output drive enable |

## Verification
The directed cases target the places where a matcher typically goes wrong:
- A repeated 0x4E38 inside a partial sequence. A design that only drops to idle would lose the restart.
- A write at step five. A design that does not abort on writes would issue a spurious command.
- A mismatching sixth address, which must produce no pulse.
- Keys with addr[16] set. A design that compares all 17 bits would never fire on them.
- Reads with oe_n high, and strobes with ce_n high. These show whether the bus enable is tied to output enable, and whether deselected cycles wrongly disturb the matcher state.

Random traffic, weighted toward the next expected key, then checks the pulse timing, the float on the store and recall sixth cycle, and the flag updates against a reference model written from the requirements.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

    localparam int KEY_W = 16;

    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_READ    = 2'd1,
        MODE_WRITE   = 2'd2
    } bus_mode_t;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_K1   = 3'd1,
        ST_K2   = 3'd2,
        ST_K3   = 3'd3,
        ST_K4   = 3'd4,
        ST_K5   = 3'd5
    } seq_state_t;

    localparam int NUM_CMD = 4;
    localparam int CMD_IDX_AS_OFF = 0;
    localparam int CMD_IDX_AS_ON  = 1;
    localparam int CMD_IDX_STORE  = 2;
    localparam int CMD_IDX_RECALL = 3;

    localparam logic [KEY_W-1:0] KEY_1 = 16'h4E38;
    localparam logic [KEY_W-1:0] KEY_2 = 16'hB1C7;
    localparam logic [KEY_W-1:0] KEY_3 = 16'h83E0;
    localparam logic [KEY_W-1:0] KEY_4 = 16'h7C1F;
    localparam logic [KEY_W-1:0] KEY_5 = 16'h703F;

    localparam logic [KEY_W-1:0] OP_AS_OFF = 16'h8B45;
    localparam logic [KEY_W-1:0] OP_AS_ON  = 16'h4B46;
    localparam logic [KEY_W-1:0] OP_STORE  = 16'h8FC0;
    localparam logic [KEY_W-1:0] OP_RECALL = 16'h4C63;

    function automatic logic [NUM_CMD-1:0] op_decode(input logic [KEY_W-1:0] k);
        logic [NUM_CMD-1:0] v;
        v = '0;
        v[CMD_IDX_AS_OFF] = (k == OP_AS_OFF);
        v[CMD_IDX_AS_ON]  = (k == OP_AS_ON);
        v[CMD_IDX_STORE]  = (k == OP_STORE);
        v[CMD_IDX_RECALL] = (k == OP_RECALL);
        return v;
    endfunction

endpackage

// File: rtl/bus_mode_decode.sv
module bus_mode_decode
    import nvseq_pkg::*;
(
    input  logic      ce_n,
    input  logic      we_n,
    input  logic      oe_n,
    input  logic      float_req,
    output bus_mode_t mode,
    output logic      io_oe
);

    always_comb begin
        if (ce_n) begin
            mode = MODE_STANDBY;
        end else if (!we_n) begin
            mode = MODE_WRITE;
        end else begin
            mode = MODE_READ;
        end
    end

    always_comb begin
        io_oe = (mode == MODE_READ) && !oe_n && !float_req;
    end

endmodule

// File: rtl/unlock_fsm.sv
module unlock_fsm
    import nvseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strobe,
    input  bus_mode_t          mode,
    input  logic [KEY_W-1:0]   key,
    output logic [NUM_CMD-1:0] pulse,
    output logic               float_req
);

    seq_state_t          state_q, state_d;
    logic [NUM_CMD-1:0]  pulse_q, pulse_d;
    logic [KEY_W-1:0]    expect_key;
    logic [NUM_CMD-1:0]  op_hit;
    logic                rd_access;
    logic                wr_access;

    assign rd_access = strobe && (mode == MODE_READ);
    assign wr_access = strobe && (mode == MODE_WRITE);
    assign op_hit    = op_decode(key);

    always_comb begin
        unique case (state_q)
            ST_IDLE: expect_key = KEY_1;
            ST_K1:   expect_key = KEY_2;
            ST_K2:   expect_key = KEY_3;
            ST_K3:   expect_key = KEY_4;
            ST_K4:   expect_key = KEY_5;
            default: expect_key = '0;
        endcase
    end

    // Next state and command generation
    always_comb begin
        state_d = state_q;
        pulse_d = '0;
        if (wr_access) begin
            state_d = ST_IDLE;
        end else if (rd_access) begin
            unique case (state_q)
                ST_IDLE, ST_K1, ST_K2, ST_K3, ST_K4: begin
                    if (key == expect_key) begin
                        state_d = seq_state_t'(state_q + 3'd1);
                    end else if (key == KEY_1) begin
                        state_d = ST_K1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
                ST_K5: begin
                    pulse_d = op_hit;
                    state_d = (key == KEY_1) ? ST_K1 : ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pulse_q <= '0;
        end else begin
            state_q <= state_d;
            pulse_q <= pulse_d;
        end
    end

    // Outputs
    always_comb begin
        pulse     = pulse_q;
        float_req = (state_q == ST_K5) &&
                    (op_hit[CMD_IDX_STORE] || op_hit[CMD_IDX_RECALL]);
    end

    a_r9_onehot_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulse_q));

    a_r9_single_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (|pulse_q) |=> !(|pulse_q));

    a_r7_write_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        wr_access |=> (state_q == ST_IDLE) && !(|pulse_q));

    a_r1_deselect_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && mode == MODE_STANDBY) |=> $stable(state_q) && !(|pulse_q));

    a_r4_pulse_needs_k5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_access && state_q == ST_K5) |=> !(|pulse_q));

endmodule

// File: rtl/autostore_flag.sv
module autostore_flag
    import nvseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CMD-1:0] pulse,
    output logic               enabled
);

    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b1;
        end else if (pulse[CMD_IDX_AS_OFF]) begin
            flag_q <= 1'b0;
        end else if (pulse[CMD_IDX_AS_ON]) begin
            flag_q <= 1'b1;
        end
    end

    assign enabled = flag_q;

    a_r10_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        pulse[CMD_IDX_AS_OFF] |=> !flag_q);

    a_r10_on_sets: assert property (@(posedge clk) disable iff (!rst_n)
        pulse[CMD_IDX_AS_ON] |=> flag_q);

    a_r10_nv_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse[CMD_IDX_STORE] || pulse[CMD_IDX_RECALL]) |=> $stable(flag_q));

endmodule

// File: rtl/nv_cmd_detect.sv
module nv_cmd_detect
    import nvseq_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              strobe,
    output logic              cmd_as_off,
    output logic              cmd_as_on,
    output logic              cmd_store,
    output logic              cmd_recall,
    output logic              autostore_on,
    output logic [1:0]        mode,
    output logic              io_oe
);

    bus_mode_t          mode_w;
    logic               float_w;
    logic [NUM_CMD-1:0] pulse_w;
    logic [KEY_W-1:0]   key_w;

    assign key_w = addr[KEY_W-1:0];

    bus_mode_decode u_decode (
        .ce_n      (ce_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .float_req (float_w),
        .mode      (mode_w),
        .io_oe     (io_oe)
    );

    unlock_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (strobe),
        .mode      (mode_w),
        .key       (key_w),
        .pulse     (pulse_w),
        .float_req (float_w)
    );

    autostore_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse   (pulse_w),
        .enabled (autostore_on)
    );

    assign mode       = mode_w;
    assign cmd_as_off = pulse_w[CMD_IDX_AS_OFF];
    assign cmd_as_on  = pulse_w[CMD_IDX_AS_ON];
    assign cmd_store  = pulse_w[CMD_IDX_STORE];
    assign cmd_recall = pulse_w[CMD_IDX_RECALL];

    a_r1_standby_float: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !io_oe && (mode == 2'd0));

    a_r2_write_float: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) |-> !io_oe && (mode == 2'd2));

    a_r3_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !io_oe);

endmodule

// File: tb/nv_cmd_detect_bench.sv
module nv_cmd_detect_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, strobe = 1'b0;
    logic [16:0] addr = '0;
    logic        cmd_as_off, cmd_as_on, cmd_store, cmd_recall, autostore_on, io_oe;
    logic [1:0]  mode;

    int n_tests = 0;
    int n_fail  = 0;
    int m_state = 0;
    bit m_flag  = 1'b1;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    nv_cmd_detect u_nv_cmd_detect (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .strobe(strobe), .cmd_as_off(cmd_as_off), .cmd_as_on(cmd_as_on),
        .cmd_store(cmd_store), .cmd_recall(cmd_recall), .autostore_on(autostore_on),
        .mode(mode), .io_oe(io_oe)
    );

    function automatic logic [15:0] key_at(int s);
        case (s)
            0: return 16'h4E38;
            1: return 16'hB1C7;
            2: return 16'h83E0;
            3: return 16'h7C1F;
            default: return 16'h703F;
        endcase
    endfunction

    // bit0 off, bit1 on, bit2 store, bit3 recall
    function automatic logic [3:0] op_of(logic [15:0] k);
        case (k)
            16'h8B45: return 4'b0001;
            16'h4B46: return 4'b0010;
            16'h8FC0: return 4'b0100;
            16'h4C63: return 4'b1000;
            default:  return 4'b0000;
        endcase
    endfunction

    function automatic logic [1:0] exp_mode(logic c, logic w);
        if (c) return 2'd0;
        if (!w) return 2'd2;
        return 2'd1;
    endfunction

    function automatic logic exp_io(logic c, logic w, logic o, int st, logic [15:0] k);
        if (c || !w || o) return 1'b0;
        if (st == 5 && (op_of(k) == 4'b0100 || op_of(k) == 4'b1000)) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(logic c, logic w, logic o, logic [16:0] a, logic s);
        logic [3:0] fire;
        @(negedge clk);
        ce_n = c; we_n = w; oe_n = o; addr = a; strobe = s;
        #1;
        check("R1 R2 R3 mode", int'(mode), int'(exp_mode(c, w)));
        check("R1 R2 R3 R8 io_oe", int'(io_oe), int'(exp_io(c, w, o, m_state, a[15:0])));
        fire = 4'b0000;
        if (s && !c) begin
            if (!w) begin
                m_state = 0;
            end else if (m_state == 5) begin
                fire = op_of(a[15:0]);
                m_state = (a[15:0] == 16'h4E38) ? 1 : 0;
            end else if (a[15:0] == key_at(m_state)) begin
                m_state++;
            end else begin
                m_state = (a[15:0] == 16'h4E38) ? 1 : 0;
            end
        end
        @(posedge clk);
        #1;
        check("R4 R5 R6 R7 R9 pulse", int'({cmd_recall, cmd_store, cmd_as_on, cmd_as_off}), int'(fire));
        check("R10 flag", int'(autostore_on), int'(m_flag));
        if (fire[0]) m_flag = 1'b0;
        else if (fire[1]) m_flag = 1'b1;
    endtask

    task automatic unlock(logic hi);
        for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b0, {hi, key_at(i)}, 1'b1);
    endtask

    task automatic idle_cyc();
        cyc(1'b1, 1'b1, 1'b1, 17'h0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset flag", int'(autostore_on), 1);
        check("R9 reset pulses", int'({cmd_recall, cmd_store, cmd_as_on, cmd_as_off}), 0);
        check("R1 reset mode", int'(mode), 0);
        rst_n = 1'b1;
        idle_cyc();

        // R5: each command; R10 flag transitions; R8 float on store/recall
        unlock(1'b0); cyc(1'b0, 1'b1, 1'b0, 17'h08B45, 1'b1); idle_cyc();
        check("R10 flag off", int'(autostore_on), 0);
        unlock(1'b0); cyc(1'b0, 1'b1, 1'b0, 17'h08FC0, 1'b1); idle_cyc();
        check("R10 store keeps flag", int'(autostore_on), 0);
        unlock(1'b0); cyc(1'b0, 1'b1, 1'b0, 17'h04B46, 1'b1); idle_cyc();
        check("R10 flag on", int'(autostore_on), 1);
        unlock(1'b0); cyc(1'b0, 1'b1, 1'b0, 17'h04C63, 1'b1); idle_cyc();

        // R6: bit 16 set on every address
        unlock(1'b1); cyc(1'b0, 1'b1, 1'b0, 17'h18FC0, 1'b1);

        // R7: write at step five aborts
        unlock(1'b0); cyc(1'b0, 1'b0, 1'b0, 17'h0703F, 1'b1); cyc(1'b0, 1'b1, 1'b0, 17'h08FC0, 1'b1);

        // R7: repeated first key restarts at step one
        cyc(1'b0, 1'b1, 1'b0, 17'h04E38, 1'b1); cyc(1'b0, 1'b1, 1'b0, 17'h0B1C7, 1'b1);
        cyc(1'b0, 1'b1, 1'b0, 17'h04E38, 1'b1);
        for (int i = 1; i < 5; i++) cyc(1'b0, 1'b1, 1'b0, {1'b0, key_at(i)}, 1'b1);
        cyc(1'b0, 1'b1, 1'b0, 17'h04C63, 1'b1);

        // R5: unmatched sixth address
        unlock(1'b0); cyc(1'b0, 1'b1, 1'b0, 17'h01234, 1'b1); cyc(1'b0, 1'b1, 1'b0, 17'h08FC0, 1'b1);

        // R3 R8: oe_n high during series, enable series sixth drives data
        for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b1, {1'b0, key_at(i)}, 1'b1);
        cyc(1'b0, 1'b1, 1'b0, 17'h08B45, 1'b1);

        // R1 R4: deselected strobes and strobe-low cycles hold the matcher
        cyc(1'b0, 1'b1, 1'b0, 17'h04E38, 1'b1); cyc(1'b1, 1'b0, 1'b0, 17'h00000, 1'b1);
        cyc(1'b0, 1'b1, 1'b0, 17'h0B1C7, 1'b1); cyc(1'b0, 1'b0, 1'b0, 17'h05555, 1'b0);
        for (int i = 2; i < 5; i++) cyc(1'b0, 1'b1, 1'b0, {1'b0, key_at(i)}, 1'b1);
        cyc(1'b0, 1'b1, 1'b0, 17'h04B46, 1'b1);

        // R2: write with oe_n low and high
        cyc(1'b0, 1'b0, 1'b0, 17'h00001, 1'b1); cyc(1'b0, 1'b0, 1'b1, 17'h00002, 1'b1);

        // Random traffic biased toward the next key
        begin
            int seed;
            seed = $urandom(32'h5EED);
            for (int n = 0; n < 3000; n++) begin
                logic c, w, o, s, h;
                logic [15:0] k;
                int r;
                c = ($urandom_range(99) < 6);
                w = ($urandom_range(99) >= 8);
                o = ($urandom_range(99) < 15);
                s = ($urandom_range(99) < 90);
                h = 1'($urandom_range(1));
                r = $urandom_range(99);
                if (m_state == 5) begin
                    case ($urandom_range(4))
                        0: k = 16'h8B45;
                        1: k = 16'h4B46;
                        2: k = 16'h8FC0;
                        3: k = 16'h4C63;
                        default: k = 16'($urandom);
                    endcase
                end else if (r < 75) k = key_at(m_state);
                else if (r < 85) k = 16'h4E38;
                else k = 16'($urandom);
                cyc(c, w, o, {h, k}, s);
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule